// File: doc/BRIEF.md
# Line-Buffered VGA Scan Converter

This block turns a small monochrome source bitmap (384 by 192 dots by default) into a standard 800 by 600 VGA raster. Every source dot is shown for two dot clocks and every source line for three output lines. The resulting 768 by 576 image sits in the middle of the visible area, with a black border of 16 dots on the left and right and 12 lines on the top and bottom. The outputs are positive horizontal and vertical sync, a display-enable flag and a one-bit pixel.

No merged framebuffer is kept. A source line is fetched only once, during the horizontal blanking just before the first of its three output lines. The fetch reads a fixed number of 32-bit words from two planes that share one word address: a text plane and an overlay plane. Each word pair is ORed when the overlay enable is high, or the text word is taken alone when it is low. The result goes into the back half of a pair of line buffers, and the halves swap at the next line start. The displayed line is shifted out most significant bit first. The memory returns data one cycle after a request.

Top module: `vga_line_scaler`

## Requirements
- R1: Each output line lasts H_ACT+H_FP+H_SYNC+H_BP dot clocks, in this order: active, front porch, sync, back porch. hsync is high exactly during the H_SYNC dots. disp_en is high during the H_ACT dots of an active line.
- R2: Each frame lasts V_ACT+V_FP+V_SYNC+V_BP lines, in this order: active, front porch, sync, back porch. The line count advances at the end of each output line, and vsync is high for exactly the V_SYNC lines.
- R3: After hsync falls, disp_en stays low for all H_BP back-porch dots before the first active dot.
- R4: pixel is low in the borders: on the first BORDER_L and the last BORDER_L dots of an active line, on the first BORDER_T and the last BORDER_T active lines, and whenever disp_en is low.
- R5: Inside the image, column c (counted from the left edge of the image) shows line-buffer bit number WORD_W-1-((c/HREP) mod WORD_W) of buffer word (c/HREP)/WORD_W. Each source bit is therefore held for HREP dots, starting with the most significant bit.
- R6: Image line r (counted from the top edge of the image) shows source line r/VREP. A new source line appears at the first dot of the first of its VREP output lines and stays unchanged for all VREP lines.
- R7: Each buffer word is text_word|ovl_word when ovl_en is high in the cycle the data returns, and text_word alone when ovl_en is low.
- R8: A source line s is fetched once, as WORDS requests on consecutive cycles. The requests start at the first front-porch dot of the output line just before the first of its VREP lines. The addresses run s*WORDS, s*WORDS+1, and so on, in ascending order, and data is expected one cycle after each request. mem_req is low at all other times.
- R9: While rst is high, and in the first cycle after it is released, hsync, vsync, disp_en, pixel and mem_req are low. Timing then starts from the first back-porch dot of the first vertical back-porch line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| ovl_en | input | 1 | Overlay enable, sampled when fetched data returns |
| mem_req | output | 1 | Word read request to both planes |
| mem_addr | output | $clog2(SRC_H*SRC_W/WORD_W) | Word address shared by both planes |
| text_word | input | WORD_W | Text plane data, one cycle after request |
| ovl_word | input | WORD_W | Overlay plane data, one cycle after request |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | High during the visible area |
| pixel | output | 1 | Dot value, black in borders |

## Verification
Source rows are chosen to separate the failure modes. A row with an empty text plane and a hashed overlay shows whether the overlay is ORed in or ignored. A row whose words have only their most and least significant bits set shows the bit order and the two-dot hold. Hashed rows catch wrong word addresses or row selection. The overlay enable alternates across fetch lines in a pattern that differs between the two frames run, so both merge modes land on different rows. Every dot is compared with a behavioural raster model, so a sync, porch or border placement off by a single dot or line is reported.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        PH_ACT  = 2'd0,
        PH_FP   = 2'd1,
        PH_SYNC = 2'd2,
        PH_BP   = 2'd3
    } phase_e;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_ACT:  return PH_FP;
            PH_FP:   return PH_SYNC;
            PH_SYNC: return PH_BP;
            default: return PH_ACT;
        endcase
    endfunction

endpackage

// File: rtl/scan_phase_counter.sv
module scan_phase_counter
    import scan_pkg::*;
#(
    parameter int ACT  = 800,
    parameter int FP   = 40,
    parameter int SYNC = 128,
    parameter int BP   = 88,
    parameter int CW   = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    logic [CW-1:0] last_c;

    always_comb begin
        case (phase)
            PH_ACT:  last_c = CW'(ACT - 1);
            PH_FP:   last_c = CW'(FP - 1);
            PH_SYNC: last_c = CW'(SYNC - 1);
            default: last_c = CW'(BP - 1);
        endcase
    end

    assign wrap = adv && (phase == PH_BP) && (cnt == CW'(BP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_BP;
            cnt   <= '0;
        end else if (adv) begin
            if (cnt == last_c) begin
                cnt   <= '0;
                phase <= next_phase(phase);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_c);

    // R1
    wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase == PH_ACT) && (cnt == '0));

endmodule

// File: rtl/scan_line_fill.sv
module scan_line_fill #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 12,
    parameter int RW     = 8,
    parameter int AW     = 12,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RW-1:0]     row,
    input  logic              swap,
    input  logic              ovl_en,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] text_word,
    input  logic [WORD_W-1:0] ovl_word,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    localparam logic [AW-1:0] WORDS_A = AW'(WORDS);

    logic [WORD_W-1:0] lbuf [2][WORDS];
    logic              fsel;
    logic              busy;
    logic              wr_pend;
    logic [IW-1:0]     widx;
    logic [IW-1:0]     wr_idx;
    logic [RW-1:0]     row_q;

    assign mem_req  = busy;
    assign mem_addr = AW'(row_q) * WORDS_A + AW'(widx);
    assign rd_word  = lbuf[fsel][rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            wr_pend <= 1'b0;
            widx    <= '0;
            wr_idx  <= '0;
            row_q   <= '0;
            fsel    <= 1'b0;
        end else begin
            wr_pend <= busy;
            wr_idx  <= widx;
            if (start) begin
                busy  <= 1'b1;
                widx  <= '0;
                row_q <= row;
            end else if (busy) begin
                if (widx == IW'(WORDS - 1)) busy <= 1'b0;
                widx <= widx + 1'b1;
            end
            if (swap) fsel <= ~fsel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_pend)
            lbuf[~fsel][wr_idx] <= ovl_en ? (text_word | ovl_word) : text_word;
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R6
    swap_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        swap |-> !busy && !wr_pend);

endmodule

// File: rtl/scan_serializer.sv
module scan_serializer #(
    parameter int WORD_W = 32,
    parameter int SRC_W  = 384,
    parameter int HREP   = 2,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              col_active,
    input  logic [WORD_W-1:0] word,
    output logic [IW-1:0]     rd_idx,
    output logic              bit_out
);

    localparam int BW = $clog2(SRC_W + 1);
    localparam int WB = $clog2(WORD_W);
    localparam int HW = (HREP > 1) ? $clog2(HREP) : 1;

    logic [BW-1:0] bit_idx;
    logic [HW-1:0] hold;
    logic [WB-1:0] sel;

    assign rd_idx  = IW'(bit_idx >> WB);
    assign sel     = WB'(WORD_W - 1) - bit_idx[WB-1:0];
    assign bit_out = word[sel];

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            bit_idx <= '0;
            hold    <= '0;
        end else if (col_active) begin
            if (hold == HW'(HREP - 1)) begin
                hold    <= '0;
                bit_idx <= bit_idx + 1'b1;
            end else begin
                hold <= hold + 1'b1;
            end
        end
    end

    // R5
    line_restart_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (bit_idx == '0) && (hold == '0));

endmodule

// File: rtl/vga_line_scaler.sv
module vga_line_scaler
    import scan_pkg::*;
#(
    parameter int SRC_W    = 384,
    parameter int SRC_H    = 192,
    parameter int WORD_W   = 32,
    parameter int HREP     = 2,
    parameter int VREP     = 3,
    parameter int H_ACT    = 800,
    parameter int H_FP     = 40,
    parameter int H_SYNC   = 128,
    parameter int H_BP     = 88,
    parameter int V_ACT    = 600,
    parameter int V_FP     = 1,
    parameter int V_SYNC   = 4,
    parameter int V_BP     = 23,
    parameter int BORDER_L = 16,
    parameter int BORDER_T = 12
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    ovl_en,
    output logic                                    mem_req,
    output logic [$clog2(SRC_H*SRC_W/WORD_W)-1:0]   mem_addr,
    input  logic [WORD_W-1:0]                       text_word,
    input  logic [WORD_W-1:0]                       ovl_word,
    output logic                                    hsync,
    output logic                                    vsync,
    output logic                                    disp_en,
    output logic                                    pixel
);

    localparam int WORDS = SRC_W / WORD_W;
    localparam int IMG_W = SRC_W * HREP;
    localparam int IMG_H = SRC_H * VREP;
    localparam int AW    = $clog2(SRC_H * WORDS);
    localparam int RW    = (SRC_H > 1) ? $clog2(SRC_H) : 1;
    localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int PW    = (VREP > 1) ? $clog2(VREP) : 1;
    localparam int HCW   = $clog2(H_ACT + H_FP + H_SYNC + H_BP);
    localparam int VCW   = $clog2(V_ACT + V_FP + V_SYNC + V_BP);

    phase_e         hphase, vphase;
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    logic           hwrap, vwrap;

    scan_phase_counter #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .CW(HCW)) h_ctr_i (
        .clk(clk), .rst(rst), .adv(1'b1), .phase(hphase), .cnt(hcnt), .wrap(hwrap));

    scan_phase_counter #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .CW(VCW)) v_ctr_i (
        .clk(clk), .rst(rst), .adv(hwrap), .phase(vphase), .cnt(vcnt), .wrap(vwrap));

    // Next output line, as seen from anywhere in the current line.
    logic           nxt_act, nxt_in_img, nxt_top, nxt_first;
    logic [VCW-1:0] nxt_idx;
    logic [RW-1:0]  nxt_row;
    logic           cur_in_img;
    logic [RW-1:0]  cur_row;
    logic [PW-1:0]  cur_rep;

    always_comb begin
        nxt_act = 1'b0;
        nxt_idx = '0;
        if (vphase == PH_ACT && vcnt != VCW'(V_ACT - 1)) begin
            nxt_act = 1'b1;
            nxt_idx = vcnt + 1'b1;
        end else if (vphase == PH_BP && vcnt == VCW'(V_BP - 1)) begin
            nxt_act = 1'b1;
        end
        nxt_in_img = nxt_act && nxt_idx >= VCW'(BORDER_T) && nxt_idx < VCW'(BORDER_T + IMG_H);
        nxt_top    = nxt_act && nxt_idx == VCW'(BORDER_T);
        nxt_first  = nxt_in_img && (nxt_top || cur_rep == PW'(VREP - 1));
        nxt_row    = nxt_top ? '0 : (cur_rep == PW'(VREP - 1) ? cur_row + 1'b1 : cur_row);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_in_img <= 1'b0;
            cur_row    <= '0;
            cur_rep    <= '0;
        end else if (hwrap) begin
            cur_in_img <= nxt_in_img;
            if (nxt_in_img) begin
                cur_row <= nxt_row;
                cur_rep <= nxt_first ? '0 : cur_rep + 1'b1;
            end
        end
    end

    logic              fill_start;
    logic [IW-1:0]     rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic              h_img, ser_bit;

    assign fill_start = (hphase == PH_ACT) && (hcnt == HCW'(H_ACT - 1)) && nxt_first;

    scan_line_fill #(.WORD_W(WORD_W), .WORDS(WORDS), .RW(RW), .AW(AW), .IW(IW)) fill_i (
        .clk(clk), .rst(rst), .start(fill_start), .row(nxt_row),
        .swap(hwrap && nxt_first), .ovl_en(ovl_en),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .text_word(text_word), .ovl_word(ovl_word),
        .rd_idx(rd_idx), .rd_word(rd_word));

    assign h_img = (hphase == PH_ACT) && hcnt >= HCW'(BORDER_L) && hcnt < HCW'(BORDER_L + IMG_W);

    scan_serializer #(.WORD_W(WORD_W), .SRC_W(SRC_W), .HREP(HREP), .IW(IW)) ser_i (
        .clk(clk), .rst(rst), .line_start(hwrap), .col_active(h_img),
        .word(rd_word), .rd_idx(rd_idx), .bit_out(ser_bit));

    assign hsync   = (hphase == PH_SYNC);
    assign vsync   = (vphase == PH_SYNC);
    assign disp_en = (hphase == PH_ACT) && (vphase == PH_ACT);
    assign pixel   = h_img && cur_in_img && ser_bit;

    // R4
    border_black_chk: assert property (@(posedge clk) disable iff (rst)
        pixel |-> disp_en);

    // R8
    fill_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> hphase != PH_ACT);

    // R2
    vsync_line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> $past(hwrap));

endmodule

// File: tb/vga_line_scaler_tb_top.sv
module vga_line_scaler_tb_top;

    localparam int SRC_W = 64, SRC_H = 4, WORD_W = 32, HREP = 2, VREP = 3;
    localparam int H_ACT = 136, H_FP = 4, H_SYNC = 8, H_BP = 6;
    localparam int V_ACT = 16, V_FP = 1, V_SYNC = 2, V_BP = 3;
    localparam int BL = 4, BT = 2;
    localparam int WORDS = SRC_W / WORD_W;
    localparam int IMG_W = SRC_W * HREP;
    localparam int IMG_H = SRC_H * VREP;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int AW = $clog2(SRC_H * WORDS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ovl_en = 1'b0;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic [WORD_W-1:0] text_word = '0;
    logic [WORD_W-1:0] ovl_word = '0;
    logic hsync, vsync, disp_en, pixel;

    always #5 clk = ~clk;

    vga_line_scaler #(
        .SRC_W(SRC_W), .SRC_H(SRC_H), .WORD_W(WORD_W), .HREP(HREP), .VREP(VREP),
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .BORDER_L(BL), .BORDER_T(BT)
    ) dut_i (
        .clk(clk), .rst(rst), .ovl_en(ovl_en), .mem_req(mem_req), .mem_addr(mem_addr),
        .text_word(text_word), .ovl_word(ovl_word),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .pixel(pixel));

    function automatic logic [31:0] tpat(input int a);
        int r = a / WORDS;
        if (r == 0) return 32'h0;
        if (r == 1) return 32'h8000_0001;
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] opat(input int a);
        if (a / WORDS == 1) return 32'h0;
        return (a * 32'h85EB_CA6B) ^ 32'h0F0F_3C3C;
    endfunction

    // memory: one cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            text_word <= tpat(int'(mem_addr));
            ovl_word  <= opat(int'(mem_addr));
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    int fills[$];

    initial begin
        int h, v, frame, shown;
        shown = -1;
        repeat (3) begin
            @(negedge clk);
            chk("R9", "reset hsync", int'(hsync), 0);
            chk("R9", "reset vsync", int'(vsync), 0);
            chk("R9", "reset disp_en", int'(disp_en), 0);
            chk("R9", "reset pixel", int'(pixel), 0);
            chk("R9", "reset mem_req", int'(mem_req), 0);
        end
        rst = 1'b0;
        h = H_ACT + H_FP + H_SYNC;
        v = V_ACT + V_FP + V_SYNC;
        frame = 0;
        for (int cyc = 0; cyc < 2 * H_TOT * V_TOT + 3 * H_TOT; cyc++) begin
            int il, ic, nv, nil, c, w;
            logic [31:0] wd;
            bit exp_req, exp_pix, hs, vs, de;
            if (h == 0) ovl_en = (((v + 3 * frame) % 4) < 2);
            hs = (h >= H_ACT + H_FP) && (h < H_ACT + H_FP + H_SYNC);
            vs = (v >= V_ACT + V_FP) && (v < V_ACT + V_FP + V_SYNC);
            de = (h < H_ACT) && (v < V_ACT);
            il = v - BT;
            ic = h - BL;
            if (h == 0 && v < V_ACT && il >= 0 && il < IMG_H && il % VREP == 0) begin
                if (fills.size() == 0) chk("R6", "fill queue empty", 1, 0);
                else shown = fills.pop_front();
            end
            chk("R1", "hsync", int'(hsync), int'(hs));
            chk("R2", "vsync", int'(vsync), int'(vs));
            if (h >= H_ACT + H_FP + H_SYNC) chk("R3", "disp_en in back porch", int'(disp_en), 0);
            else chk("R1", "disp_en", int'(disp_en), int'(de));
            // pixel
            if (!(de && il >= 0 && il < IMG_H && ic >= 0 && ic < IMG_W)) begin
                chk("R4", "border pixel", int'(pixel), 0);
            end else begin
                c = ic / HREP;
                w = (shown >> 1) * WORDS + c / WORD_W;
                wd = (shown & 1) ? (tpat(w) | opat(w)) : tpat(w);
                exp_pix = wd[WORD_W - 1 - (c % WORD_W)];
                if ((shown >> 1) != il / VREP) chk("R6", "row shown", shown >> 1, il / VREP);
                if (il % VREP != 0) chk("R6", "repeated line pixel", int'(pixel), int'(exp_pix));
                else if (shown & 1) chk("R7", "merged pixel", int'(pixel), int'(exp_pix));
                else chk("R5", "text pixel", int'(pixel), int'(exp_pix));
            end
            // memory fetch
            nv = (v + 1) % V_TOT;
            nil = nv - BT;
            exp_req = (nv < V_ACT) && nil >= 0 && nil < IMG_H && (nil % VREP == 0) &&
                      (h >= H_ACT) && (h < H_ACT + WORDS);
            chk("R8", "mem_req", int'(mem_req), int'(exp_req));
            if (exp_req) begin
                chk("R8", "mem_addr", int'(mem_addr), (nil / VREP) * WORDS + (h - H_ACT));
                if (h == H_ACT) fills.push_back((nil / VREP) * 2 + int'(ovl_en));
            end
            h++;
            if (h == H_TOT) begin
                h = 0;
                v++;
                if (v == V_TOT) begin
                    v = 0;
                    frame++;
                end
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule